// File: doc/BRIEF.md
# Supply Brownout Reset Sequencer

This block turns a digital supply-good flag, produced by an external voltage comparator, into the system reset. From power-on it holds reset active. It lets reset go only after the supply has stayed good for a programmable number of timebase ticks. If the supply drops below the threshold at any point, reset comes back on the next clock. A dip during the hold window throws away the count so far, and the full window starts again.

A watchdog reset request is merged into the same output. A build-time parameter sets the output polarity, so one source file gives both the active-low and the active-high variant. The supply-good input is asynchronous and passes through a synchroniser chain first. The tick strobe comes from a slow on-chip timebase, for example one pulse per millisecond, so the hold window is HOLD_TICKS of those periods.

Top module: `brownout_rst_seq`

## Requirements
- R1: While rst_ni is low, and on the clocks right after it rises, the reset output is active: rst_o is 0 with RST_ACTIVE_HIGH=0 and 1 with RST_ACTIVE_HIGH=1.
- R2: supply_ok_i passes through SYNC_STAGES flip-flops before it has any effect. With the default of 2, a change presented before clock edge k is first seen by the release logic at edge k+2.
- R3: Reset is released one clock after the edge that counts the HOLD_TICKS-th tick_i pulse. Every one of those pulses must be seen while the synchronised supply is good.
- R4: Whenever the synchronised supply is low, the tick count is cleared. Any dip during the hold window, even one clock long, restarts the full window.
- R5: Once released, a low synchronised supply makes the output active at the next clock edge.
- R6: While the synchronised supply stays low, the output stays active no matter how many ticks arrive.
- R7: A high wdog_req_i makes the output active at the next edge. It does not clear a finished hold window, so the output is inactive again one edge after the request drops, provided the supply stays good.
- R8: RST_ACTIVE_HIGH only inverts the output. The active-high build always drives the complement of the active-low build for the same inputs.
- R9: Once released with the supply good, further tick_i pulses never re-arm or reassert the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| supply_ok_i | input | 1 | Asynchronous comparator flag, 1 means supply above threshold |
| tick_i | input | 1 | Single-cycle timebase strobe that paces the hold window |
| wdog_req_i | input | 1 | Synchronous watchdog reset request, active high |
| rst_o | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |

## Verification
Two kinds of corrupted internal state show up differently at the port. A stuck or mis-cleared tick counter moves the release edge. An early or late release becomes a one-clock mismatch on rst_o, seen on the first cycle the window should close or should still be open. A synchroniser of the wrong depth shifts the brownout assertion by a clock, and this shows on the first supply drop. A release flag that survives a dip makes reset come back early after a glitch. The bench compares every clock against an independent model, so each of these faults is caught within one cycle of becoming observable, in both polarity builds at once.

// File: rtl/brownout_rst_pkg.sv
package brownout_rst_pkg;
  typedef enum logic {
    HOLD_WAIT = 1'b0,
    HOLD_DONE = 1'b1
  } hold_state_e;
endpackage

// File: rtl/brownout_sync.sv
module brownout_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= RST_VAL;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/brownout_hold_timer.sv
module brownout_hold_timer
  import brownout_rst_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic tick_i,
  output logic released_o
);
  localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  hold_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HOLD_WAIT;
      cnt_q   <= '0;
    end else if (!good_i) begin
      // any dip restarts the whole window
      state_q <= HOLD_WAIT;
      cnt_q   <= '0;
    end else if (state_q == HOLD_WAIT && tick_i) begin
      if (cnt_q == CNT_LAST) begin
        state_q <= HOLD_DONE;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign released_o = (state_q == HOLD_DONE);
endmodule

// File: rtl/brownout_rst_drive.sv
module brownout_rst_drive #(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic released_i,
  input  logic wdog_req_i,
  output logic rst_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b1;
    else         active_q <= !good_i || !released_i || wdog_req_i;
  end

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign rst_o = active_q;
    end else begin : g_low
      assign rst_o = ~active_q;
    end
  endgenerate
endmodule

// File: rtl/brownout_rst_seq.sv
module brownout_rst_seq #(
  parameter int unsigned HOLD_TICKS      = 200,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic tick_i,
  input  logic wdog_req_i,
  output logic rst_o
);
  logic supply_ok_sync;
  logic released;

  brownout_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (supply_ok_i),
    .q_o    (supply_ok_sync)
  );

  brownout_hold_timer #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .good_i     (supply_ok_sync),
    .tick_i     (tick_i),
    .released_o (released)
  );

  brownout_rst_drive #(
    .ACTIVE_HIGH (RST_ACTIVE_HIGH)
  ) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .good_i     (supply_ok_sync),
    .released_i (released),
    .wdog_req_i (wdog_req_i),
    .rst_o      (rst_o)
  );
endmodule

// File: rtl/brownout_rst_seq_chk.sv
module brownout_rst_seq_chk #(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wdog_req_i,
  input logic sync_ok_i,
  input logic released_i,
  input logic rst_o
);
  logic active;
  assign active = ACTIVE_HIGH ? rst_o : ~rst_o;

  assert_brownout_assert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ok_i |=> active);

  assert_dip_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ok_i |=> !released_i);

  assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(released_i) |-> ($past(tick_i) && $past(sync_ok_i)));

  assert_wdog_asserts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_req_i |=> active);

  assert_stays_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (released_i && sync_ok_i) |=> released_i);

  assert_low_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_ok_i && !released_i) |=> !released_i);
endmodule

bind brownout_rst_seq brownout_rst_seq_chk #(
  .ACTIVE_HIGH (RST_ACTIVE_HIGH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wdog_req_i (wdog_req_i),
  .sync_ok_i  (supply_ok_sync),
  .released_i (released),
  .rst_o      (rst_o)
);

// File: tb/brownout_rst_seq_tb.sv
module brownout_rst_seq_tb;
  localparam int HOLD = 5;
  localparam int SYNC = 2;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic tick = 1'b0;
  logic wdog = 1'b0;
  logic rst_lo, rst_hi;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string phase = "R1";
  bit cmp_en = 1'b0;
  bit tick_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brownout_rst_seq #(.HOLD_TICKS(HOLD), .SYNC_STAGES(SYNC), .RST_ACTIVE_HIGH(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .tick_i(tick),
    .wdog_req_i(wdog), .rst_o(rst_lo));

  brownout_rst_seq #(.HOLD_TICKS(HOLD), .SYNC_STAGES(SYNC), .RST_ACTIVE_HIGH(1'b1)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .tick_i(tick),
    .wdog_req_i(wdog), .rst_o(rst_hi));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  logic q[$];
  bit m_rel;
  int m_cnt;
  bit m_active;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q = {};
      for (int i = 0; i < SYNC; i++) q.push_back(1'b0);
      m_rel = 0; m_cnt = 0; m_active = 1;
    end else begin
      bit sok;
      sok = q[0];
      m_active = !sok || !m_rel || wdog;
      if (!sok) begin
        m_rel = 0; m_cnt = 0;
      end else if (!m_rel && tick) begin
        m_cnt++;
        if (m_cnt == HOLD) begin m_rel = 1; m_cnt = 0; end
      end
      q.push_back(supply_ok);
      void'(q.pop_front());
    end
  end

  // tick strobe and per-cycle comparison, driven away from the active edge
  int tdiv = 0;
  always @(negedge clk) begin
    cyc++;
    if (tick_en) begin
      tdiv = (tdiv + 1) % TICK_DIV;
      tick <= (tdiv == 0);
    end else tick <= 1'b0;
    if (cmp_en) begin
      chk(phase, rst_lo, ~m_active);
      chk("R8", rst_hi, ~rst_lo);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_n(4);
    // R1: reset state while rst_ni low
    chk("R1", rst_lo, 1'b0);
    chk("R1", rst_hi, 1'b1);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    tick_en = 1'b1;
    wait_n(20);
    chk("R1", rst_lo, 1'b0);  // supply still low, no release

    // R3: supply good, window completes
    phase = "R3";
    supply_ok = 1'b1;
    wait_n(40);
    chk("R3", rst_lo, 1'b1);

    // R9: stays released with ticks running
    phase = "R9";
    wait_n(30);
    chk("R9", rst_lo, 1'b1);

    // R2/R5: drop supply; two clean edges then active
    phase = "R5";
    supply_ok = 1'b0;
    wait_n(1); chk("R2", rst_lo, 1'b1);
    wait_n(1); chk("R2", rst_lo, 1'b1);
    wait_n(1); chk("R5", rst_lo, 1'b0);

    // R6: low supply holds reset despite ticks
    phase = "R6";
    wait_n(40);
    chk("R6", rst_lo, 1'b0);

    // R4: partial window, one-cycle glitch, window restarts
    phase = "R4";
    supply_ok = 1'b1;
    wait_n(10);
    supply_ok = 1'b0;
    wait_n(1);
    supply_ok = 1'b1;
    wait_n(12);
    chk("R4", rst_lo, 1'b0);
    wait_n(30);
    chk("R4", rst_lo, 1'b1);

    // R7: watchdog pulse while released
    phase = "R7";
    wdog = 1'b1;
    wait_n(1); chk("R7", rst_lo, 1'b0);
    wait_n(1);
    wdog = 1'b0;
    wait_n(1); chk("R7", rst_lo, 1'b1);
    wait_n(10);

    // R7: watchdog during a counting window, window not disturbed
    supply_ok = 1'b0;
    wait_n(6);
    supply_ok = 1'b1;
    wait_n(5);
    wdog = 1'b1;
    wait_n(3);
    wdog = 1'b0;
    wait_n(40);
    chk("R7", rst_lo, 1'b1);

    // R1: mid-run power-on reset
    phase = "R1";
    cmp_en = 1'b0;
    rst_ni = 1'b0;
    wait_n(2);
    chk("R1", rst_lo, 1'b0);
    chk("R1", rst_hi, 1'b1);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    phase = "R3";
    wait_n(40);
    chk("R3", rst_lo, 1'b1);

    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule